// File: doc/BRIEF.md
# Fixed-Point Complex Butterfly Datapath

This block is the arithmetic core of an in-place radix-2 transform step. Each accepted operation carries a low element and a high element, each as a real and an imaginary part, plus one cosine and one sine coefficient. The block returns the updated low and high elements on the same cycle, so that the caller can write both back over the locations it read from. All four results come from the same captured operands, so neither write-back can disturb the other.

A two-bit mode input picks one of three variants per operation. The first is the full complex butterfly, which uses a conjugate-form twiddle product. The second is a real-only twin multiply-add/subtract, applied to the real lane and the imaginary lane independently. The third is a plain twin add/subtract with no multiply. Operands and results are signed Q1.15. Products are kept at full precision until the final add or subtract. Results are rounded to nearest and clamped to the 16-bit range. The pipeline takes one new operation every cycle and has a fixed latency of three cycles.

Top module: `cbfly_core`

## Requirements
- R1: In complex mode the twiddle real term is tre = hr·cos + hi·sin. The outputs are lo_re_o = lr + tre and hi_re_o = lr − tre.
- R2: In complex mode the twiddle imaginary term is tim = hi·cos − hr·sin. The outputs are lo_im_o = li + tim and hi_im_o = li − tim.
- R3: The mode encoding is: 0 = complex, 1 = real twin multiply, 2 = plain twin add/subtract. The value 3 behaves exactly like 0.
- R4: In mode 1, each lane computes l ± h·cos independently: lo_re_o = lr + hr·cos, hi_re_o = lr − hr·cos, and the same for the imaginary lane with li and hi. The sine input has no effect on the results.
- R5: In mode 2, lo = l + h and hi = l − h per lane, with no multiply. Neither coefficient input has any effect on the results.
- R6: All values are signed Q1.15 (0x4000 = 0.5). Each exact result x (in units of 2^-30) is rounded to floor((x + 2^14) / 2^15), so a tie rounds toward plus infinity.
- R7: A rounded result above 0x7FFF is output as 0x7FFF, and one below −32768 is output as 0x8000.
- R8: An operation presented with in_vld high in cycle n appears with out_vld high in cycle n+3, and out_vld stays low in cycles n+1 and n+2. Operations in consecutive cycles come out in consecutive cycles, in order.
- R9: After reset, out_vld is low and all result outputs are zero. While out_vld is low, the result outputs keep their last values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operation present on the inputs this cycle |
| mode | input | 2 | Operation variant (see R3) |
| lo_re | input | W | Low element, real part |
| lo_im | input | W | Low element, imaginary part |
| hi_re | input | W | High element, real part |
| hi_im | input | W | High element, imaginary part |
| tw_cos | input | W | Cosine coefficient |
| tw_sin | input | W | Sine coefficient |
| out_vld | output | 1 | Results valid this cycle |
| lo_re_o | output | W | New low element, real part |
| lo_im_o | output | W | New low element, imaginary part |
| hi_re_o | output | W | New high element, real part |
| hi_im_o | output | W | New high element, imaginary part |

## Verification
A product routed to the wrong term, or a sign slip in the combine stage, shows up at the outputs exactly three cycles after the operation. It breaks the pairing between the low and high results: their sum must equal twice the old low value, within one rounding step. A valid bit that is lost or duplicated in the pipeline shows up as out_vld differing from in_vld delayed by three cycles. A stale or mis-enabled output register shows up on the first idle cycle as a result that changes while out_vld is low. Rounding and clamping faults appear only on ties and on full-scale operands, so both of those are driven on purpose.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;

   typedef enum logic [1:0] {
      BF_CPLX = 2'd0,
      BF_RMUL = 2'd1,
      BF_RADD = 2'd2,
      BF_ALT  = 2'd3
   } bf_mode_e;

endpackage

// File: rtl/cbfly_mul.sv
// Registered signed multiplier, full-width product.
module cbfly_mul #(
   parameter int AW = 16,
   parameter int BW = 16,
   localparam int PW = AW + BW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [AW-1:0] a,
   input  logic signed [BW-1:0] b,
   output logic signed [PW-1:0] p
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  p <= '0;
      else if (en) p <= PW'(a) * PW'(b);
   end

endmodule

// File: rtl/cbfly_term.sv
// Forms the two twiddle terms from the four products, per mode.
module cbfly_term
   import cbfly_pkg::*;
#(
   parameter int W    = 16,
   parameter int FRAC = 15,
   localparam int PW  = 2 * W,
   localparam int TW  = PW + 1
) (
   input  bf_mode_e             mode,
   input  logic signed [PW-1:0] p_rc,
   input  logic signed [PW-1:0] p_is,
   input  logic signed [PW-1:0] p_rs,
   input  logic signed [PW-1:0] p_ic,
   input  logic signed [W-1:0]  h_re,
   input  logic signed [W-1:0]  h_im,
   output logic signed [TW-1:0] t_re,
   output logic signed [TW-1:0] t_im
);

   localparam int XH = TW - W - FRAC;

   logic signed [TW-1:0] e_rc, e_is, e_rs, e_ic, a_re, a_im;

   always_comb begin
      e_rc = {p_rc[PW-1], p_rc};
      e_is = {p_is[PW-1], p_is};
      e_rs = {p_rs[PW-1], p_rs};
      e_ic = {p_ic[PW-1], p_ic};
      a_re = {{XH{h_re[W-1]}}, h_re, {FRAC{1'b0}}};
      a_im = {{XH{h_im[W-1]}}, h_im, {FRAC{1'b0}}};
      case (mode)
         BF_RMUL: begin
            t_re = e_rc;
            t_im = e_ic;
         end
         BF_RADD: begin
            t_re = a_re;
            t_im = a_im;
         end
         default: begin
            t_re = e_rc + e_is;
            t_im = e_ic - e_rs;
         end
      endcase
   end

endmodule

// File: rtl/cbfly_rndsat.sv
// Round half toward +inf at FRAC, then clamp to OW signed bits.
module cbfly_rndsat #(
   parameter int IW   = 34,
   parameter int FRAC = 15,
   parameter int OW   = 16
) (
   input  logic signed [IW-1:0] x,
   output logic signed [OW-1:0] y
);

   localparam int XW = IW + 1;
   localparam logic signed [XW-1:0] MAXV = {{(XW-OW+1){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [XW-1:0] MINV = {{(XW-OW+1){1'b1}}, {(OW-1){1'b0}}};

   logic signed [XW-1:0] xe, xr, sh;

   assign xe = {x[IW-1], x};

   if (FRAC == 0) begin : g_trunc
      assign xr = xe;
   end else begin : g_rnd
      localparam logic signed [XW-1:0] HALF = XW'(1) <<< (FRAC - 1);
      assign xr = xe + HALF;
   end

   assign sh = xr >>> FRAC;

   always_comb begin
      if (sh > MAXV)      y = MAXV[OW-1:0];
      else if (sh < MINV) y = MINV[OW-1:0];
      else                y = sh[OW-1:0];
   end

endmodule

// File: rtl/cbfly_core.sv
// In-place complex radix-2 butterfly, three register stages.
module cbfly_core
   import cbfly_pkg::*;
#(
   parameter int W    = 16,
   parameter int FRAC = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [1:0]   mode,
   input  logic [W-1:0] lo_re,
   input  logic [W-1:0] lo_im,
   input  logic [W-1:0] hi_re,
   input  logic [W-1:0] hi_im,
   input  logic [W-1:0] tw_cos,
   input  logic [W-1:0] tw_sin,
   output logic         out_vld,
   output logic [W-1:0] lo_re_o,
   output logic [W-1:0] lo_im_o,
   output logic [W-1:0] hi_re_o,
   output logic [W-1:0] hi_im_o
);

   localparam int PW    = 2 * W;
   localparam int TW    = PW + 1;
   localparam int SW    = TW + 1;
   localparam int NMUL  = 4;
   localparam int NOUT  = 4;
   localparam int LH    = SW - W - FRAC;

   if (W < 4) begin : g_bad_w
      $error("cbfly_core: W must be at least 4");
   end
   if (FRAC < 1 || FRAC >= W) begin : g_bad_frac
      $error("cbfly_core: FRAC must lie in 1..W-1");
   end

   // ---------------- stage 1: products ----------------
   logic signed [W-1:0]  mul_a [NMUL];
   logic signed [W-1:0]  mul_b [NMUL];
   logic signed [PW-1:0] prod  [NMUL];

   always_comb begin
      mul_a[0] = hi_re;  mul_b[0] = tw_cos;   // hr*cos
      mul_a[1] = hi_im;  mul_b[1] = tw_sin;   // hi*sin
      mul_a[2] = hi_re;  mul_b[2] = tw_sin;   // hr*sin
      mul_a[3] = hi_im;  mul_b[3] = tw_cos;   // hi*cos
   end

   for (genvar g = 0; g < NMUL; g++) begin : g_mul
      cbfly_mul #(.AW(W), .BW(W)) u_mul (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (in_vld),
         .a     (mul_a[g]),
         .b     (mul_b[g]),
         .p     (prod[g])
      );
   end

   logic                s1_vld;
   bf_mode_e            s1_mode;
   logic signed [W-1:0] s1_lr, s1_li, s1_hr, s1_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_mode <= BF_CPLX;
         s1_lr   <= '0;
         s1_li   <= '0;
         s1_hr   <= '0;
         s1_hi   <= '0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_mode <= bf_mode_e'(mode);
            s1_lr   <= lo_re;
            s1_li   <= lo_im;
            s1_hr   <= hi_re;
            s1_hi   <= hi_im;
         end
      end
   end

   // ---------------- stage 2: twiddle terms ----------------
   logic signed [TW-1:0] t_re, t_im;

   cbfly_term #(.W(W), .FRAC(FRAC)) u_term (
      .mode (s1_mode),
      .p_rc (prod[0]),
      .p_is (prod[1]),
      .p_rs (prod[2]),
      .p_ic (prod[3]),
      .h_re (s1_hr),
      .h_im (s1_hi),
      .t_re (t_re),
      .t_im (t_im)
   );

   logic                 s2_vld;
   logic signed [W-1:0]  s2_lr, s2_li;
   logic signed [TW-1:0] s2_tre, s2_tim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;
         s2_lr  <= '0;
         s2_li  <= '0;
         s2_tre <= '0;
         s2_tim <= '0;
      end else begin
         s2_vld <= s1_vld;
         if (s1_vld) begin
            s2_lr  <= s1_lr;
            s2_li  <= s1_li;
            s2_tre <= t_re;
            s2_tim <= t_im;
         end
      end
   end

   // ---------------- stage 3: sum/difference, round, clamp ----------------
   logic signed [SW-1:0] la_re, la_im, te_re, te_im;
   logic signed [SW-1:0] sums [NOUT];
   logic signed [W-1:0]  rsat [NOUT];

   always_comb begin
      la_re   = {{LH{s2_lr[W-1]}}, s2_lr, {FRAC{1'b0}}};
      la_im   = {{LH{s2_li[W-1]}}, s2_li, {FRAC{1'b0}}};
      te_re   = {s2_tre[TW-1], s2_tre};
      te_im   = {s2_tim[TW-1], s2_tim};
      sums[0] = la_re + te_re;   // low real
      sums[1] = la_im + te_im;   // low imaginary
      sums[2] = la_re - te_re;   // high real
      sums[3] = la_im - te_im;   // high imaginary
   end

   for (genvar g = 0; g < NOUT; g++) begin : g_rs
      cbfly_rndsat #(.IW(SW), .FRAC(FRAC), .OW(W)) u_rs (
         .x (sums[g]),
         .y (rsat[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         lo_re_o <= '0;
         lo_im_o <= '0;
         hi_re_o <= '0;
         hi_im_o <= '0;
      end else begin
         out_vld <= s2_vld;
         if (s2_vld) begin
            lo_re_o <= rsat[0];
            lo_im_o <= rsat[1];
            hi_re_o <= rsat[2];
            hi_im_o <= rsat[3];
         end
      end
   end

endmodule

// File: rtl/cbfly_core_chk.sv
module cbfly_core_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_vld,
   input logic [1:0]   mode,
   input logic [W-1:0] lo_re,
   input logic [W-1:0] lo_im,
   input logic [W-1:0] hi_re,
   input logic [W-1:0] hi_im,
   input logic [W-1:0] tw_cos,
   input logic [W-1:0] tw_sin,
   input logic         out_vld,
   input logic [W-1:0] lo_re_o,
   input logic [W-1:0] lo_im_o,
   input logic [W-1:0] hi_re_o,
   input logic [W-1:0] hi_im_o
);

   localparam logic [W-1:0] RAIL_P = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] RAIL_N = {1'b1, {(W-1){1'b0}}};

   logic [1:0]   cyc_q;
   logic         vld_d  [3];
   logic [1:0]   mode_d [3];
   logic [W-1:0] lr_d [3], li_d [3], hr_d [3], c_d [3], s_d [3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         for (int i = 0; i < 3; i++) begin
            vld_d[i] <= 1'b0; mode_d[i] <= '0; lr_d[i] <= '0; li_d[i] <= '0;
            hr_d[i] <= '0; c_d[i] <= '0; s_d[i] <= '0;
         end
      end else begin
         if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
         vld_d[0] <= in_vld; mode_d[0] <= mode; lr_d[0] <= lo_re; li_d[0] <= lo_im;
         hr_d[0] <= hi_re; c_d[0] <= tw_cos; s_d[0] <= tw_sin;
         for (int i = 1; i < 3; i++) begin
            vld_d[i] <= vld_d[i-1]; mode_d[i] <= mode_d[i-1]; lr_d[i] <= lr_d[i-1];
            li_d[i] <= li_d[i-1]; hr_d[i] <= hr_d[i-1]; c_d[i] <= c_d[i-1]; s_d[i] <= s_d[i-1];
         end
      end
   end

   logic warm, rails, sum_mode;
   logic signed [W+1:0] pr_re, pr_im, df_re;

   always_comb begin
      warm  = (cyc_q == 2'd3);
      rails = (lo_re_o == RAIL_P) || (lo_re_o == RAIL_N) || (hi_re_o == RAIL_P) ||
              (hi_re_o == RAIL_N) || (lo_im_o == RAIL_P) || (lo_im_o == RAIL_N) ||
              (hi_im_o == RAIL_P) || (hi_im_o == RAIL_N);
      sum_mode = (mode_d[2] == 2'd0) || (mode_d[2] == 2'd3);
      pr_re = $signed({{2{lo_re_o[W-1]}}, lo_re_o}) + $signed({{2{hi_re_o[W-1]}}, hi_re_o})
            - $signed({lr_d[2][W-1], lr_d[2], 1'b0});
      pr_im = $signed({{2{lo_im_o[W-1]}}, lo_im_o}) + $signed({{2{hi_im_o[W-1]}}, hi_im_o})
            - $signed({li_d[2][W-1], li_d[2], 1'b0});
      df_re = $signed({{2{lo_re_o[W-1]}}, lo_re_o}) - $signed({{2{hi_re_o[W-1]}}, hi_re_o})
            - $signed({hr_d[2][W-1], hr_d[2], 1'b0});
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_vld == vld_d[2])); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !out_vld) |-> ($stable(lo_re_o) && $stable(lo_im_o) && $stable(hi_re_o) && $stable(hi_im_o))); // R9

   AST_PAIR_RE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld && !rails) |-> (pr_re == 0 || pr_re == 1)); // R1

   AST_PAIR_IM: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld && !rails) |-> (pr_im == 0 || pr_im == 1)); // R2

   AST_ADD_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld && !rails && mode_d[2] == 2'd2) |-> (df_re == 0)); // R5

   AST_ZERO_TWIDDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld && sum_mode && c_d[2] == '0 && s_d[2] == '0) |->
      (lo_re_o == lr_d[2] && hi_re_o == lr_d[2] && lo_im_o == li_d[2] && hi_im_o == li_d[2])); // R3

endmodule

bind cbfly_core cbfly_core_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .mode    (mode),
   .lo_re   (lo_re),
   .lo_im   (lo_im),
   .hi_re   (hi_re),
   .hi_im   (hi_im),
   .tw_cos  (tw_cos),
   .tw_sin  (tw_sin),
   .out_vld (out_vld),
   .lo_re_o (lo_re_o),
   .lo_im_o (lo_im_o),
   .hi_re_o (hi_re_o),
   .hi_im_o (hi_im_o)
);

// File: tb/sim_cbfly_core.sv
module sim_cbfly_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [1:0]  mode = '0;
   logic [15:0] lo_re = '0, lo_im = '0, hi_re = '0, hi_im = '0, tw_cos = '0, tw_sin = '0;
   logic        out_vld;
   logic [15:0] lo_re_o, lo_im_o, hi_re_o, hi_im_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cbfly_core u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode),
      .lo_re(lo_re), .lo_im(lo_im), .hi_re(hi_re), .hi_im(hi_im),
      .tw_cos(tw_cos), .tw_sin(tw_sin), .out_vld(out_vld),
      .lo_re_o(lo_re_o), .lo_im_o(lo_im_o), .hi_re_o(hi_re_o), .hi_im_o(hi_im_o)
   );

   function automatic logic [15:0] rnd_sat(input longint x);
      longint y;
      y = (x + 64'sd16384) >>> 15;
      if (y > 32767)  y = 32767;
      if (y < -32768) y = -32768;
      return y[15:0];
   endfunction

   // returns {lo_re, lo_im, hi_re, hi_im}
   function automatic logic [63:0] model(input logic [1:0] m,
         input logic signed [15:0] lr, li, hr, hi, c, s);
      longint tre, tim, lar, lai;
      lar = longint'(lr) * 32768;
      lai = longint'(li) * 32768;
      case (m)
         2'd1: begin tre = longint'(hr) * longint'(c); tim = longint'(hi) * longint'(c); end
         2'd2: begin tre = longint'(hr) * 32768; tim = longint'(hi) * 32768; end
         default: begin
            tre = longint'(hr) * longint'(c) + longint'(hi) * longint'(s);
            tim = longint'(hi) * longint'(c) - longint'(hr) * longint'(s);
         end
      endcase
      return {rnd_sat(lar + tre), rnd_sat(lai + tim), rnd_sat(lar - tre), rnd_sat(lai - tim)};
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [63:0] exp);
      chk(req, "lo_re_o", lo_re_o, exp[63:48]);
      chk(req, "lo_im_o", lo_im_o, exp[47:32]);
      chk(req, "hi_re_o", hi_re_o, exp[31:16]);
      chk(req, "hi_im_o", hi_im_o, exp[15:0]);
   endtask

   task automatic drive(input logic [1:0] m, input logic [15:0] a, b, c, d, e, f);
      mode = m; lo_re = a; lo_im = b; hi_re = c; hi_im = d; tw_cos = e; tw_sin = f;
   endtask

   // one operation, checks timing (R8) and results against the model
   task automatic do_op(input string req, input logic [1:0] m,
                        input logic [15:0] a, b, c, d, e, f);
      @(negedge clk); drive(m, a, b, c, d, e, f); in_vld = 1'b1;
      @(negedge clk); in_vld = 1'b0; drive(2'd0, 16'h1234, 16'h4321, 16'h5555, 16'haaaa, 16'h7777, 16'h0101);
      chk("R8", "out_vld at n+1", {15'd0, out_vld}, 16'd0);
      @(negedge clk);
      chk("R8", "out_vld at n+2", {15'd0, out_vld}, 16'd0);
      @(negedge clk);
      chk("R8", "out_vld at n+3", {15'd0, out_vld}, 16'd1);
      chk_all(req, model(m, a, b, c, d, e, f));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9", "out_vld in reset", {15'd0, out_vld}, 16'd0);
      chk_all("R9", 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "out_vld after reset", {15'd0, out_vld}, 16'd0);
   endtask

   task automatic t_cplx;
      // R1 R2: worked example, then varied signs
      do_op("R1", 2'd0, 16'h1000, 16'h0800, 16'h2000, 16'he000, 16'h4000, 16'h2000);
      chk("R1", "lo_re literal", lo_re_o, 16'd6144);
      chk("R1", "hi_re literal", hi_re_o, 16'd2048);
      chk("R2", "lo_im literal", lo_im_o, 16'hf000);
      chk("R2", "hi_im literal", hi_im_o, 16'd8192);
      do_op("R2", 2'd0, 16'hc123, 16'h3abc, 16'h5a5a, 16'h9876, 16'h5a82, 16'ha57e);
      do_op("R1", 2'd0, 16'h0001, 16'hffff, 16'h7fff, 16'h8000, 16'h0003, 16'hfffd);
   endtask

   task automatic t_alt_mode;
      // R3: mode 3 gives the same as mode 0
      do_op("R3", 2'd3, 16'h1000, 16'h0800, 16'h2000, 16'he000, 16'h4000, 16'h2000);
      chk("R3", "mode3 lo_re", lo_re_o, 16'd6144);
      chk("R3", "mode3 hi_im", hi_im_o, 16'd8192);
   endtask

   task automatic t_rmul;
      logic [15:0] keep;
      do_op("R4", 2'd1, 16'h0400, 16'hfc00, 16'h2000, 16'h1000, 16'h4000, 16'h7fff);
      keep = lo_re_o;
      chk("R4", "lo_re literal", lo_re_o, 16'h1400);
      chk("R4", "hi_im literal", hi_im_o, 16'hf400);
      do_op("R4", 2'd1, 16'h0400, 16'hfc00, 16'h2000, 16'h1000, 16'h4000, 16'h8000);
      chk("R4", "sine ignored", lo_re_o, keep);
   endtask

   task automatic t_radd;
      do_op("R5", 2'd2, 16'h0123, 16'hff00, 16'h0011, 16'h0100, 16'h7fff, 16'h7fff);
      chk("R5", "lo_re literal", lo_re_o, 16'h0134);
      chk("R5", "hi_im literal", hi_im_o, 16'hfe00);
      do_op("R5", 2'd2, 16'h0123, 16'hff00, 16'h0011, 16'h0100, 16'h0000, 16'h8000);
      chk("R5", "coef ignored", hi_re_o, 16'h0112);
   endtask

   task automatic t_round;
      // tie: +0.5 lsb rounds up, -0.5 lsb rounds to 0
      do_op("R6", 2'd1, 16'h0000, 16'h0000, 16'h0001, 16'hffff, 16'h4000, 16'h0000);
      chk("R6", "tie lo_re", lo_re_o, 16'h0001);
      chk("R6", "tie hi_re", hi_re_o, 16'h0000);
      chk("R6", "tie lo_im", lo_im_o, 16'h0000);
      chk("R6", "tie hi_im", hi_im_o, 16'h0001);
   endtask

   task automatic t_sat;
      do_op("R7", 2'd0, 16'h7fff, 16'h8000, 16'h7fff, 16'h8000, 16'h7fff, 16'h0000);
      chk("R7", "clamp high", lo_re_o, 16'h7fff);
      chk("R7", "clamp low", lo_im_o, 16'h8000);
      do_op("R7", 2'd2, 16'h8000, 16'h7fff, 16'h7fff, 16'h7fff, 16'h0000, 16'h0000);
      chk("R7", "add clamp low", hi_re_o, 16'h8000);
      chk("R7", "add clamp high", lo_im_o, 16'h7fff);
   endtask

   task automatic t_stream;
      logic [15:0] v [6][6];
      logic [1:0]  m [6];
      for (int i = 0; i < 6; i++) begin
         m[i] = 2'(i % 3);
         for (int k = 0; k < 6; k++) v[i][k] = 16'((i * 7919 + k * 4099 + 311) * 13);
      end
      for (int cyc = 0; cyc < 9; cyc++) begin
         @(negedge clk);
         if (cyc >= 3) begin
            chk("R8", "stream out_vld", {15'd0, out_vld}, 16'd1);
            chk_all("R8", model(m[cyc-3], v[cyc-3][0], v[cyc-3][1], v[cyc-3][2],
                                v[cyc-3][3], v[cyc-3][4], v[cyc-3][5]));
         end
         if (cyc < 6) begin
            drive(m[cyc], v[cyc][0], v[cyc][1], v[cyc][2], v[cyc][3], v[cyc][4], v[cyc][5]);
            in_vld = 1'b1;
         end else begin
            in_vld = 1'b0;
         end
      end
   endtask

   task automatic t_hold;
      logic [63:0] last;
      do_op("R9", 2'd0, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h2000, 16'h1000);
      last = {lo_re_o, lo_im_o, hi_re_o, hi_im_o};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         drive(2'(i), 16'(i * 999), 16'hbeef, 16'h7fff, 16'h8000, 16'h7fff, 16'h7fff);
         chk("R9", "idle out_vld", {15'd0, out_vld}, 16'd0);
         chk_all("R9", last);
      end
   endtask

   initial begin
      t_reset();
      t_cplx();
      t_alt_mode();
      t_rmul();
      t_radd();
      t_round();
      t_sat();
      t_stream();
      t_hold();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule